// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Mute and Freeze

This block buffers PCM samples on the transmit side of an audio serializer. A bus-side producer writes samples into a 64-entry queue, and the serializer asks for one sample per request. Each answer appears on a registered output one cycle after the request. A single control word holds a six-bit threshold and two read-mode bits. A level output stays high while the queue holds fewer samples than the threshold, so the producer knows when to refill it.

The two read modes change what a request delivers and whether it uses up an entry. In silence mode every answer is zero, but entries are still taken from the queue at the normal rate, so the stream keeps its timing. In hold mode the last sample taken from the queue is sent again and the queue is left untouched. Hold mode can also be forced by an external debug pin. If both modes are active, hold decides that the queue is not touched and silence decides that the output is zero. A write that finds the queue full is dropped. A request that finds the queue empty outside hold mode returns zero. Each of these two events sets its own sticky flag.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset, cfg_rdata, fill_level, rd_data, trig_evt, ovf_flag and unf_flag are all zero.
- R2: A cfg_we write stores the threshold from bits 5:0, silence mode from bit 16 and hold mode from bit 17. cfg_rdata returns those bits in the same positions and zero in every other bit.
- R3: trig_evt is high exactly when fill_level is strictly less than the threshold. With a threshold of 0 it is never high.
- R4: With both modes off and the queue not empty, a request takes the oldest entry. That entry appears on rd_data on the next cycle and fill_level drops by one. Samples leave in the order they were written.
- R5: In silence mode (hold off), a request on a non-empty queue puts zero on rd_data and still takes one entry, so fill_level drops by one.
- R6: In hold mode (silence off), a request puts the last sample taken from the queue back on rd_data and leaves fill_level unchanged.
- R7: A high dbg_freeze acts exactly like the hold-mode bit, even when that bit is clear.
- R8: With both modes active, a request puts zero on rd_data and leaves fill_level unchanged.
- R9: fill_level never exceeds 64. A write while fill_level is 64 is dropped, whether or not a read happens in the same cycle, and sets ovf_flag, which stays set until reset.
- R10: A request on an empty queue outside hold mode puts zero on rd_data, leaves fill_level at 0 and sets unf_flag, which stays set until reset.
- R11: A write and a request that both take effect in the same cycle leave fill_level unchanged.
- R12: The replay sample is zero after reset. It is updated with the head sample on every request that takes an entry, in silence mode as well as in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback |
| wr_valid | input | 1 | Sample write strobe |
| wr_data | input | 16 | Sample to enqueue |
| rd_req | input | 1 | Serializer sample request |
| rd_data | output | 16 | Delivered sample, registered |
| dbg_freeze | input | 1 | External force into hold mode |
| fill_level | output | 7 | Number of queued samples |
| trig_evt | output | 1 | Occupancy is below the threshold |
| ovf_flag | output | 1 | Sticky: a write was dropped |
| unf_flag | output | 1 | Sticky: a request found the queue empty |

## Verification
Properties are checked on every cycle: occupancy stays within bounds, a simultaneous write and take holds the count, hold mode never takes an entry, silence and empty requests answer zero, hold mode answers with the stored replay sample, the trigger stays low at threshold zero, and the sticky flags stay set. Only the directed scenarios can show sample ordering across many writes, that the dropped write is really absent after a full drain, that the replay register follows silenced takes, that the debug pin behaves the same as the control bit, and that the threshold compare is right at its boundary values.

// File: rtl/audtx_pkg.sv
package audtx_pkg;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned LVL_W    = 6;
  localparam int unsigned LVL_LSB  = 0;
  localparam int unsigned MUTE_POS = 16;
  localparam int unsigned FRZ_POS  = 17;

  typedef struct packed {
    logic             freeze;
    logic             mute;
    logic [LVL_W-1:0] level;
  } audtx_cfg_t;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_HEAD   = 2'd1,
    RD_REPLAY = 2'd2,
    RD_ZERO   = 2'd3
  } rd_mode_e;

  // Place the control fields into a readback word; unused bits are zero.
  function automatic logic [CFG_W-1:0] cfg_pack(audtx_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[LVL_LSB +: LVL_W] = c.level;
    w[MUTE_POS]         = c.mute;
    w[FRZ_POS]          = c.freeze;
    return w;
  endfunction

  // Threshold compare: strictly below.
  function automatic logic below_level(int unsigned cnt, int unsigned lvl);
    return cnt < lvl;
  endfunction
endpackage

// File: rtl/audtx_ctrl.sv
module audtx_ctrl
  import audtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output audtx_cfg_t       cfg_q,
  output logic [CFG_W-1:0] cfg_rdata
);
  audtx_cfg_t cfg_d;
  logic       unused_cfg_bits;

  always_comb begin
    cfg_d.level  = cfg_wdata[LVL_LSB +: LVL_W];
    cfg_d.mute   = cfg_wdata[MUTE_POS];
    cfg_d.freeze = cfg_wdata[FRZ_POS];
  end

  assign unused_cfg_bits = ^{cfg_wdata[CFG_W-1:FRZ_POS+1],
                             cfg_wdata[MUTE_POS-1:LVL_LSB+LVL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign cfg_rdata = cfg_pack(cfg_q);

  // R2: readback never shows bits outside the three fields
  assert_cfg_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~32'h0003_003F) == '0);
endmodule

// File: rtl/audtx_store.sv
module audtx_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_req,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       pop_req,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH):0]     fill,
  output logic                       empty,
  output logic                       full,
  output logic                       push_ok,
  output logic                       drop_evt
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     fill_q;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] fill_next(logic [CW-1:0] f, logic in_ok, logic out_ok);
    case ({in_ok, out_ok})
      2'b10:   return f + 1'b1;
      2'b01:   return f - 1'b1;
      default: return f;
    endcase
  endfunction

  assign empty    = (fill_q == '0);
  assign full     = (fill_q == FULL_CNT);
  assign push_ok  = push_req && !full;
  assign drop_evt = push_req && full;
  assign head     = mem[rd_ptr];
  assign fill     = fill_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_req) rd_ptr <= ptr_inc(rd_ptr);
      fill_q <= fill_next(fill_q, push_ok, pop_req);
    end
  end

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL_CNT);
  assert_no_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |-> !empty);
  assert_pushpop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_req) |=> $stable(fill_q));
  assert_drop_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !pop_req) |=> (fill_q == FULL_CNT));
endmodule

// File: rtl/audtx_read_sel.sv
module audtx_read_sel
  import audtx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              mute,
  input  logic              freeze_eff,
  input  logic              empty,
  input  logic [DATA_W-1:0] head,
  output logic              pop,
  output logic              under_evt,
  output logic [DATA_W-1:0] rd_data
);
  rd_mode_e          mode;
  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    mode      = RD_IDLE;
    pop       = 1'b0;
    under_evt = 1'b0;
    if (rd_req) begin
      if (freeze_eff) begin
        mode = mute ? RD_ZERO : RD_REPLAY;
      end else if (empty) begin
        mode      = RD_ZERO;
        under_evt = 1'b1;
      end else begin
        mode = mute ? RD_ZERO : RD_HEAD;
        pop  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      rd_q   <= '0;
    end else begin
      if (pop) prev_q <= head;
      case (mode)
        RD_HEAD:   rd_q <= head;
        RD_REPLAY: rd_q <= prev_q;
        RD_ZERO:   rd_q <= '0;
        default:   rd_q <= rd_q;
      endcase
    end
  end

  assign rd_data = rd_q;

  assert_mute_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && mute) |=> (rd_data == '0));
  assert_freeze_nopop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_eff |-> !pop);
  assert_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && freeze_eff && !mute) |=> (rd_data == $past(prev_q)));
  assert_both_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && freeze_eff && mute) |=> (rd_data == '0));
  assert_under_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty && !freeze_eff) |=> (rd_data == '0));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data));
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import audtx_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic                   wr_valid,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rd_req,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   dbg_freeze,
  output logic [$clog2(DEPTH):0] fill_level,
  output logic                   trig_evt,
  output logic                   ovf_flag,
  output logic                   unf_flag
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  audtx_cfg_t        cfg_q;
  logic              freeze_eff;
  logic              pop, under_evt;
  logic              empty, full, push_ok, drop_evt;
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     fill;
  logic              ovf_q, unf_q;

  audtx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .cfg_rdata (cfg_rdata)
  );

  assign freeze_eff = cfg_q.freeze | dbg_freeze;

  audtx_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (wr_valid),
    .wdata    (wr_data),
    .pop_req  (pop),
    .head     (head),
    .fill     (fill),
    .empty    (empty),
    .full     (full),
    .push_ok  (push_ok),
    .drop_evt (drop_evt)
  );

  audtx_read_sel #(.DATA_W(DATA_W)) u_read (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .mute       (cfg_q.mute),
    .freeze_eff (freeze_eff),
    .empty      (empty),
    .head       (head),
    .pop        (pop),
    .under_evt  (under_evt),
    .rd_data    (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (drop_evt)  ovf_q <= 1'b1;
      if (under_evt) unf_q <= 1'b1;
    end
  end

  assign fill_level = fill;
  assign trig_evt   = below_level(32'(fill), 32'(cfg_q.level));
  assign ovf_flag   = ovf_q;
  assign unf_flag   = unf_q;

  assert_trig_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.level == '0) |-> !trig_evt);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);
  assert_freeze_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && dbg_freeze && !wr_valid) |=> $stable(fill_level));
  assert_full_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_ok);
endmodule

// File: tb/test_audio_tx_fifo.sv
module test_audio_tx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_data;
  logic        dbg_freeze = 1'b0;
  logic [6:0]  fill_level;
  logic        trig_evt, ovf_flag, unf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  audio_tx_fifo i_audio_tx_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .dbg_freeze(dbg_freeze),
    .fill_level(fill_level), .trig_evt(trig_evt), .ovf_flag(ovf_flag),
    .unf_flag(unf_flag)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w; step(); cfg_we = 1'b0;
  endtask

  task automatic push(logic [15:0] d);
    wr_valid = 1'b1; wr_data = d; step(); wr_valid = 1'b0;
  endtask

  task automatic req();
    rd_req = 1'b1; step(); rd_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cfg_rdata", cfg_rdata, 0);
    chk("R1 fill", 32'(fill_level), 0);
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 flags", {29'd0, trig_evt, ovf_flag, unf_flag}, 0);
  endtask

  task automatic t_replay_reset();
    cfg(32'h0002_0000);
    req();
    chk("R12 replay after reset", 32'(rd_data), 0);
    chk("R6 fill held empty", 32'(fill_level), 0);
    chk("R10 no underflow in hold", 32'(unf_flag), 0);
    cfg(0);
  endtask

  task automatic t_cfg();
    cfg(32'hFFFF_FFFF);
    chk("R2 readback all ones", cfg_rdata, 32'h0003_003F);
    chk("R3 level 63 at fill 0", 32'(trig_evt), 1);
    cfg(32'h0001_0005);
    chk("R2 readback mixed", cfg_rdata, 32'h0001_0005);
    cfg(0);
    chk("R2 readback zero", cfg_rdata, 0);
  endtask

  task automatic t_trigger_normal();
    cfg(32'h0000_0004);
    chk("R3 below at fill 0", 32'(trig_evt), 1);
    for (int i = 0; i < 4; i++) push(16'h1000 + 16'(i));
    chk("R3 equal level", 32'(trig_evt), 0);
    req();
    chk("R4 first out", 32'(rd_data), 32'h1000);
    chk("R4 fill dec", 32'(fill_level), 3);
    chk("R3 below again", 32'(trig_evt), 1);
    for (int i = 1; i < 4; i++) begin
      req();
      chk("R4 order", 32'(rd_data), 32'h1000 + i);
    end
    cfg(0);
    chk("R3 level 0 never", 32'(trig_evt), 0);
  endtask

  task automatic t_freeze();
    push(16'hA1A1); push(16'hB2B2);
    req();
    chk("R4 head A", 32'(rd_data), 32'hA1A1);
    cfg(32'h0002_0000);
    req();
    chk("R6 replay 1", 32'(rd_data), 32'hA1A1);
    req();
    chk("R6 replay 2", 32'(rd_data), 32'hA1A1);
    chk("R6 fill held", 32'(fill_level), 1);
    cfg(0);
    req();
    chk("R6 resume B", 32'(rd_data), 32'hB2B2);
  endtask

  task automatic t_dbg();
    push(16'hC3C3);
    dbg_freeze = 1'b1;
    req();
    chk("R7 dbg replay", 32'(rd_data), 32'hB2B2);
    chk("R7 dbg fill held", 32'(fill_level), 1);
    dbg_freeze = 1'b0;
    req();
    chk("R7 release pops", 32'(rd_data), 32'hC3C3);
    chk("R7 fill after release", 32'(fill_level), 0);
  endtask

  task automatic t_mute();
    push(16'hD4D4); push(16'hE5E5); push(16'hF6F6);
    cfg(32'h0001_0000);
    req();
    chk("R5 mute zero", 32'(rd_data), 0);
    chk("R5 mute consumes", 32'(fill_level), 2);
    cfg(32'h0002_0000);
    req();
    chk("R12 replay follows muted take", 32'(rd_data), 32'hD4D4);
    cfg(32'h0003_0000);
    req();
    chk("R8 both zero", 32'(rd_data), 0);
    chk("R8 fill held", 32'(fill_level), 2);
    cfg(0);
    req();
    chk("R8 next is E", 32'(rd_data), 32'hE5E5);
  endtask

  task automatic t_pushpop();
    wr_valid = 1'b1; wr_data = 16'h0707; rd_req = 1'b1;
    step();
    wr_valid = 1'b0; rd_req = 1'b0;
    chk("R11 fill same", 32'(fill_level), 1);
    chk("R11 read head F", 32'(rd_data), 32'hF6F6);
    req();
    chk("R11 pushed kept", 32'(rd_data), 32'h0707);
  endtask

  task automatic t_underflow();
    chk("R10 no unf yet", 32'(unf_flag), 0);
    req();
    chk("R10 empty zero", 32'(rd_data), 0);
    chk("R10 fill 0", 32'(fill_level), 0);
    chk("R10 unf set", 32'(unf_flag), 1);
    step();
    chk("R10 unf sticky", 32'(unf_flag), 1);
  endtask

  task automatic t_overflow();
    int bad;
    for (int i = 0; i < 64; i++) push(16'h2000 + 16'(i));
    chk("R9 full count", 32'(fill_level), 64);
    chk("R9 no ovf yet", 32'(ovf_flag), 0);
    push(16'hDEAD);
    chk("R9 drop count", 32'(fill_level), 64);
    chk("R9 ovf set", 32'(ovf_flag), 1);
    wr_valid = 1'b1; wr_data = 16'hBEEF; rd_req = 1'b1;
    step();
    wr_valid = 1'b0; rd_req = 1'b0;
    chk("R9 drop with read", 32'(fill_level), 63);
    chk("R9 read during drop", 32'(rd_data), 32'h2000);
    bad = 0;
    for (int i = 1; i < 64; i++) begin
      req();
      if (rd_data !== 16'h2000 + 16'(i)) bad++;
    end
    chk("R9 drained order mismatches", 32'(bad), 0);
    chk("R9 drained empty", 32'(fill_level), 0);
    chk("R9 ovf sticky", 32'(ovf_flag), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_replay_reset();
    t_cfg();
    t_trigger_normal();
    t_freeze();
    t_dbg();
    t_mute();
    t_pushpop();
    t_underflow();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule